// File: doc/BRIEF.md
# Probing Signature Table

This block settles, exactly, whether a candidate byte string flagged by an approximate membership stage really belongs to the set of stored signatures. It keeps up to 2^ADDR_W entries. Each entry holds a signature of 1 to SIG_BYTES bytes, its length, an occupied flag and a deleted (tombstone) flag. A command carries an operation, a length and a signature. The block derives a home slot from an XOR-of-masked-bits hash and then visits slots at power-of-two distances from home. It stops when the operation's stop rule is met or when the probe limit is reached.

Only one command is in flight at a time. Each probe is one read of the slot store with a fixed latency of RD_LAT cycles. A result therefore appears after a number of cycles that depends on how many probes the chain needed. The result carries a code and the index of the last slot examined.

Operation codes: 0 add, 1 query, 2 delete. Code 3 behaves as query. Result codes: 0 DONE, 1 FOUND, 2 NOT_FOUND, 3 FULL.

Top module: `sig_probe_table`

## Requirements
- R1: After reset, cmd_ready is 1, res_valid is 0, and every slot is empty, so any query returns NOT_FOUND after a single probe of its home slot.
- R2: Bytes at index len and above (byte b is cmd_sig[8b+7:8b]) are treated as zero. The home slot is the XOR, over every set bit j of the masked signature, of bits [ADDR_W-1:0] of ((j+1)*40503 >> 7).
- R3: Probe k (counting from 0) examines slot home for k=0, and (home + (1 << (k-1))) mod 2^ADDR_W for k≥1. res_slot reports the last slot examined.
- R4: Add stores the signature and length in the first probed slot whose occupied flag is clear or whose deleted flag is set. That slot becomes occupied and not deleted, and the result is DONE.
- R5: Query returns FOUND at a slot that is occupied, not deleted and equal in length and masked bytes. It moves past occupied non-matching slots and deleted slots. It returns NOT_FOUND at a slot with both flags clear.
- R6: cmd_ready drops in the cycle after a command is accepted and stays low until the result. res_valid is a one-cycle pulse, raised together with cmd_ready.
- R7: If MAX_PROBES probes end without a stop, add returns FULL and query or delete returns NOT_FOUND. The table is left unchanged.
- R8: A command that uses n probes raises res_valid exactly n*(RD_LAT+2) clock cycles after the edge on which it was accepted.
- R9: Delete follows the query rules. On FOUND it sets the slot's deleted flag, so later queries miss that entry but still reach entries placed further along the same chain. On NOT_FOUND it changes nothing.
- R10: A stored entry matches only a command of the same length. Bytes of the command at or above its length have no effect on hashing or comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted when valid is high |
| cmd_op | input | 2 | 0 add, 1 query, 2 delete, 3 query |
| cmd_len | input | $clog2(SIG_BYTES+1) | Signature length in bytes, 1..SIG_BYTES |
| cmd_sig | input | SIG_BYTES*8 | Signature, byte 0 in the low bits |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 0 DONE, 1 FOUND, 2 NOT_FOUND, 3 FULL |
| res_slot | output | ADDR_W | Last slot examined |

## Verification
The hardest situation to reach is a query whose chain runs through a tombstone and then finds a live entry further along. A second hard case is an add that reuses that tombstone. Both need several signatures that share a home slot. The bench searches its own copy of the hash formula for seeds that collide, so it can place entries at home and at home+1 and then delete the first. Broad sweeps with many more signatures than slots drive chains to the probe limit and give FULL results.

// File: rtl/sig_probe_table.sv
module sig_probe_table #(
  parameter int SIG_BYTES  = 32,
  parameter int ADDR_W     = 4,
  parameter int RD_LAT     = 3,
  parameter int MAX_PROBES = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_valid,
  output logic                               cmd_ready,
  input  logic [1:0]                         cmd_op,
  input  logic [$clog2(SIG_BYTES+1)-1:0]     cmd_len,
  input  logic [SIG_BYTES*8-1:0]             cmd_sig,
  output logic                               res_valid,
  output logic [1:0]                         res_code,
  output logic [ADDR_W-1:0]                  res_slot
);
  localparam int SIG_W = SIG_BYTES * 8;
  localparam int LEN_W = $clog2(SIG_BYTES + 1);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = $clog2(MAX_PROBES + 1);
  localparam int CW    = $clog2(RD_LAT + 1);

  localparam logic [1:0] OP_ADD = 2'd0, OP_DEL = 2'd2;
  localparam logic [1:0] RC_DONE = 2'd0, RC_FOUND = 2'd1, RC_MISS = 2'd2, RC_FULL = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_CMP} st_t;

  function automatic logic [SIG_W-1:0] mask_sig(input logic [SIG_W-1:0] s, input logic [LEN_W-1:0] l);
    logic [SIG_W-1:0] m;
    m = s;
    for (int b = 0; b < SIG_BYTES; b++)
      if (b >= int'(l)) m[b*8 +: 8] = 8'h00;
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] home_of(input logic [SIG_W-1:0] s);
    logic [ADDR_W-1:0] h;
    logic [31:0]       k;
    h = '0;
    for (int j = 0; j < SIG_W; j++) begin
      k = (32'(j) + 32'd1) * 32'd40503 >> 7;
      if (s[j]) h = h ^ k[ADDR_W-1:0];
    end
    return h;
  endfunction

  logic [SIG_W-1:0]  mem_sig [DEPTH];
  logic [LEN_W-1:0]  mem_len [DEPTH];
  logic [DEPTH-1:0]  occ, del;

  st_t               st;
  logic [1:0]        c_op;
  logic [LEN_W-1:0]  c_len;
  logic [SIG_W-1:0]  c_sig;
  logic [ADDR_W-1:0] home;
  logic [PW-1:0]     probe;
  logic [CW-1:0]     cnt;
  logic [SIG_W-1:0]  rd_sig;
  logic [LEN_W-1:0]  rd_len;
  logic              rd_occ, rd_del;

  logic [SIG_W-1:0]  in_masked;
  logic [ADDR_W-1:0] offset, addr;
  logic              hit, free_slot, empty_slot, last, is_add, finish;
  logic [1:0]        code_now;

  assign cmd_ready  = (st == S_IDLE);
  assign in_masked  = mask_sig(cmd_sig, cmd_len);
  assign offset     = (probe == '0) ? '0 : (ADDR_W'(1) << (probe - PW'(1)));
  assign addr       = home + offset;

  assign is_add     = (c_op == OP_ADD);
  assign hit        = rd_occ && !rd_del && (rd_len == c_len) && (rd_sig == c_sig);
  assign free_slot  = !rd_occ || rd_del;
  assign empty_slot = !rd_occ && !rd_del;
  assign last       = (probe == PW'(MAX_PROBES - 1));
  assign finish     = is_add ? (free_slot || last) : (hit || empty_slot || last);

  always_comb begin
    if (is_add)          code_now = free_slot ? RC_DONE : RC_FULL;
    else if (hit)        code_now = RC_FOUND;
    else                 code_now = RC_MISS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      occ       <= '0;
      del       <= '0;
      res_valid <= 1'b0;
      res_code  <= RC_DONE;
      res_slot  <= '0;
      c_op      <= '0;
      c_len     <= '0;
      c_sig     <= '0;
      home      <= '0;
      probe     <= '0;
      cnt       <= '0;
      rd_sig    <= '0;
      rd_len    <= '0;
      rd_occ    <= 1'b0;
      rd_del    <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          c_op  <= cmd_op;
          c_len <= cmd_len;
          c_sig <= in_masked;
          home  <= home_of(in_masked);
          probe <= '0;
          st    <= S_RD;
        end
        S_RD: begin
          rd_sig <= mem_sig[addr];
          rd_len <= mem_len[addr];
          rd_occ <= occ[addr];
          rd_del <= del[addr];
          cnt    <= CW'(RD_LAT);
          st     <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt == CW'(1)) st <= S_CMP;
          else               cnt <= cnt - CW'(1);
        end
        S_CMP: begin
          if (finish) begin
            res_valid <= 1'b1;
            res_code  <= code_now;
            res_slot  <= addr;
            st        <= S_IDLE;
            if (is_add && free_slot) begin
              occ[addr] <= 1'b1;
              del[addr] <= 1'b0;
            end
            if (c_op == OP_DEL && hit) del[addr] <= 1'b1;
          end else begin
            probe <= probe + PW'(1);
            st    <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_CMP && is_add && free_slot) begin
      mem_sig[addr] <= c_sig;
      mem_len[addr] <= c_len;
    end
  end
endmodule

module sig_probe_table_chk #(
  parameter int RD_LAT     = 3,
  parameter int MAX_PROBES = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       res_valid,
  input logic [1:0] res_code
);
  logic [1:0]  last_op;
  logic [15:0] cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_op <= 2'd1;
      cyc     <= '0;
    end else if (cmd_valid && cmd_ready) begin
      last_op <= cmd_op;
      cyc     <= '0;
    end else if (cyc != 16'hFFFF) begin
      cyc <= cyc + 16'd1;
    end
  end

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  p_result_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_ready_with_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> cmd_ready);
  p_full_only_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'd3) |-> last_op == 2'd0);
  p_done_only_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'd0) |-> last_op == 2'd0);
  p_add_never_found_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && last_op == 2'd0) |-> res_code[1:0] != 2'd1 && res_code != 2'd2);
  p_latency_grid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(cyc) % (RD_LAT + 2) == 0) && cyc != 16'd0
                  && int'(cyc) <= MAX_PROBES * (RD_LAT + 2));
endmodule

bind sig_probe_table sig_probe_table_chk #(.RD_LAT(RD_LAT), .MAX_PROBES(MAX_PROBES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .res_valid(res_valid), .res_code(res_code)
);

// File: tb/sim_sig_probe_table.sv
module sim_sig_probe_table;
  localparam int SIG_BYTES = 32, ADDR_W = 4, RD_LAT = 3, MAX_PROBES = 5;
  localparam int SIG_W = SIG_BYTES * 8;
  localparam int LEN_W = $clog2(SIG_BYTES + 1);
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic cmd_ready, res_valid;
  logic [1:0] cmd_op = '0, res_code;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [SIG_W-1:0] cmd_sig = '0;
  logic [ADDR_W-1:0] res_slot;

  always #2.5 clk = ~clk;

  sig_probe_table #(.SIG_BYTES(SIG_BYTES), .ADDR_W(ADDR_W), .RD_LAT(RD_LAT), .MAX_PROBES(MAX_PROBES)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_len(cmd_len), .cmd_sig(cmd_sig), .res_valid(res_valid), .res_code(res_code), .res_slot(res_slot));

  int n_chk = 0, n_bad = 0, ticks = 0;
  bit finished = 0;

  logic             m_occ [DEPTH];
  logic             m_del [DEPTH];
  logic [SIG_W-1:0] m_sig [DEPTH];
  logic [LEN_W-1:0] m_len [DEPTH];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [SIG_W-1:0] tb_mask(input logic [SIG_W-1:0] s, input int len);
    logic [SIG_W-1:0] r = '0;
    for (int b = 0; b < len; b++) r[b*8 +: 8] = s[b*8 +: 8];
    return r;
  endfunction

  function automatic int tb_home(input logic [SIG_W-1:0] s);
    int h = 0;
    for (int j = 0; j < SIG_W; j++)
      if (s[j]) h = h ^ ((((j + 1) * 40503) >> 7) % DEPTH);
    return h;
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [SIG_W-1:0] mk_sig(input int seed);
    logic [SIG_W-1:0] r;
    logic [31:0] s = 32'h1234_5678 ^ (32'(seed) * 32'h9E37_79B9);
    if (s == 0) s = 1;
    for (int w = 0; w < SIG_W / 32; w++) begin s = xs(s); r[w*32 +: 32] = s; end
    return r;
  endfunction

  task automatic model_cmd(input int op, input int len, input logic [SIG_W-1:0] sig,
                           output int code, output int slot, output int n);
    logic [SIG_W-1:0] ms = tb_mask(sig, len);
    int h = tb_home(ms);
    bit stop = 0;
    code = (op == 0) ? 3 : 2; slot = h; n = 0;
    for (int k = 0; k < MAX_PROBES && !stop; k++) begin
      int a = (k == 0) ? h : (h + (1 << (k - 1))) % DEPTH;
      n = k + 1; slot = a;
      if (op == 0) begin
        if (!m_occ[a] || m_del[a]) begin
          m_occ[a] = 1; m_del[a] = 0; m_sig[a] = ms; m_len[a] = LEN_W'(len);
          code = 0; stop = 1;
        end
      end else if (m_occ[a] && !m_del[a] && int'(m_len[a]) == len && m_sig[a] == ms) begin
        code = 1; stop = 1;
        if (op == 2) m_del[a] = 1;
      end else if (!m_occ[a] && !m_del[a]) begin
        code = 2; stop = 1;
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 0; cmd_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < DEPTH; i++) begin m_occ[i] = 0; m_del[i] = 0; m_sig[i] = '0; m_len[i] = '0; end
    @(negedge clk);
  endtask

  task automatic do_cmd(input int op, input int len, input logic [SIG_W-1:0] sig, input string tag);
    int e_code, e_slot, e_n, cyc;
    model_cmd(op, len, sig, e_code, e_slot, e_n);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = 2'(op); cmd_len = LEN_W'(len); cmd_sig = sig; cmd_valid = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    check(cmd_ready == 0, "R6 ready low while busy", int'(cmd_ready), 0);
    cyc = 1;
    while (!res_valid && cyc < 2000) begin @(negedge clk); cyc++; end
    check(int'(res_code) == e_code, tag, int'(res_code), e_code);
    check(int'(res_slot) == e_slot, "R3 last probed slot", int'(res_slot), e_slot);
    check(cyc == e_n * (RD_LAT + 2) + 1, "R8 result latency", cyc, e_n * (RD_LAT + 2) + 1);
  endtask

  function automatic string op_tag(input int op);
    return op == 0 ? "R4/R7 add result" : (op == 2 ? "R9 delete result" : "R5 query result");
  endfunction

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", ticks, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [SIG_W-1:0] a_sig, b_sig, c_sig;
    int ha, sb, sc;
    do_reset();
    check(cmd_ready == 1, "R1 ready after reset", int'(cmd_ready), 1);
    check(res_valid == 0, "R1 no result after reset", int'(res_valid), 0);

    // R1 / R2: empty table, home slot reported after one probe
    for (int i = 0; i < 8; i++) do_cmd(1, (i * 5) % 32 + 1, mk_sig(500 + i), "R1 R2 empty query miss");

    // R10: length must match, bytes above length are ignored
    do_reset();
    a_sig = '0; a_sig[7:0] = 8'h41;
    do_cmd(0, 1, a_sig, "R4 add short");
    do_cmd(1, 2, a_sig, "R10 longer length misses");
    do_cmd(1, 1, a_sig | (mk_sig(7) & ~{{(SIG_W-8){1'b0}}, 8'hFF}), "R10 garbage above length found");
    do_cmd(0, 2, a_sig, "R10 same bytes other length stored apart");
    do_cmd(1, 2, a_sig, "R10 longer length now found");

    // R9: tombstone keeps the chain intact and is reused by add
    do_reset();
    a_sig = tb_mask(mk_sig(1000), 12);
    ha = tb_home(a_sig);
    sb = 1001;
    while (tb_home(tb_mask(mk_sig(sb), 12)) != ha) sb++;
    sc = sb + 1;
    while (tb_home(tb_mask(mk_sig(sc), 12)) != ha) sc++;
    b_sig = tb_mask(mk_sig(sb), 12);
    c_sig = tb_mask(mk_sig(sc), 12);
    do_cmd(0, 12, a_sig, "R4 add first of chain");
    do_cmd(0, 12, b_sig, "R4 add collides to next slot");
    do_cmd(2, 12, a_sig, "R9 delete head");
    do_cmd(1, 12, a_sig, "R9 deleted entry misses");
    do_cmd(1, 12, b_sig, "R9 chain past tombstone found");
    do_cmd(2, 12, c_sig, "R9 delete absent misses");
    do_cmd(1, 12, b_sig, "R9 absent delete changed nothing");
    do_cmd(0, 12, c_sig, "R4 add reuses tombstone");
    do_cmd(1, 12, c_sig, "R5 reused slot found");

    // Sweep: overfill, query, delete, refill
    do_reset();
    for (int i = 0; i < 28; i++) do_cmd(0, i % 32 + 1, mk_sig(i), op_tag(0));
    for (int i = 0; i < 28; i++)
      do_cmd(1, i % 32 + 1, tb_mask(mk_sig(i), i % 32 + 1) | (mk_sig(900 + i) & ~tb_mask({SIG_W{1'b1}}, i % 32 + 1)), op_tag(1));
    for (int i = 0; i < 28; i += 3) do_cmd(2, i % 32 + 1, mk_sig(i), op_tag(2));
    for (int i = 0; i < 28; i++) do_cmd(1, i % 32 + 1, mk_sig(i), op_tag(1));
    for (int i = 0; i < 28; i += 3) do_cmd(0, i % 32 + 1, mk_sig(i + 100), op_tag(0));
    for (int i = 0; i < 28; i++) do_cmd(3, i % 32 + 1, mk_sig(i + 100), op_tag(3));
    for (int i = 0; i < 40; i++) do_cmd(i % 3, (i * 7) % 32 + 1, mk_sig(i % 20), op_tag(i % 3));

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule